// File: doc/BRIEF.md
# Programmable Offset Frame Pulse Generator

This block produces a framing pulse that is displaced from a reference frame boundary by a whole number of serial channels. It runs on a 16.384 MHz master clock, so one 125 µs frame spans 2048 master cycles. A one-cycle reference strobe marks the start of each frame. A 16-bit control word selects one of four serial data rates. The rate fixes the length of one 8-bit channel in master cycles, the legal offset range and the width of the pulse. Two separate inputs choose the polarity of the pulse and whether it is centred on the offset point.

The control word, polarity and position inputs are captured only when the reference strobe arrives, so a change made in mid-frame cannot cut or double a pulse. Settings that are not legal raise an error flag, but the block still produces a pulse. The block is built with an instance index. On the instance whose index matches the special-instance parameter, a bypass bit replaces the offset pulse with an unshifted active-low pulse.

Top module: `ofp_gen`

## Requirements
- R1: The rate field ctrl_word[1:0] (00, 01, 10, 11) sets the channel length to 64, 32, 16 or 8 master cycles. The offset field ctrl_word[9:2] gives the start channel. If the strobe is high in the cycle ending at clock edge E0, the output after edge E0+k shows frame position k. The pulse begins at position offset × channel length.
- R2: The pulse lasts 4 master cycles at rate 00, 2 at rate 01, and 1 at rates 10 and 11.
- R3: The legal offset is at most 31, 63, 127 or 255 for rates 00 to 11. A larger offset sets cfg_err for that frame, and the start channel becomes the offset modulo the channel count (32, 64, 128 or 256).
- R4: Any nonzero bit in ctrl_word[15:11] sets cfg_err for that frame. The pulse is then still formed from the rate and offset fields.
- R5: When pol_sel=1 the pulse is active-high. When pol_sel=0 it is active-low. Outside the pulse the output holds the inactive level.
- R6: When pos_sel=1 the pulse starts floor(width/2) positions earlier (2, 1, 0, 0 for rates 00 to 11), wrapping modulo 2048.
- R7: On the special instance (INST_IDX == SPECIAL_INST), ctrl_word[10]=1 gives an active-low pulse of 1 cycle at position 0, whatever the offset, pol_sel and pos_sel. On any other instance the bit does not change the pulse and sets cfg_err.
- R8: ctrl_word, pol_sel and pos_sel are taken in only at a reference strobe. A change during a frame affects neither fp_out nor cfg_err until the next strobe.
- R9: After reset and until the first strobe, fp_out stays 1 and cfg_err stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16.384 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_start | input | 1 | One-cycle reference frame-start strobe |
| ctrl_word | input | 16 | Rate, offset, bypass and reserved fields |
| pol_sel | input | 1 | 1 = active-high pulse, 0 = active-low |
| pos_sel | input | 1 | 1 = pulse centred on the offset point |
| fp_out | output | 1 | Offset frame pulse |
| cfg_err | output | 1 | Illegal setting in the frame's control word |

## Verification
Every combination of rate, polarity and position is run with an offset that differs for each combination. These runs tell the channel length, the pulse width and the centring shift apart at each rate. At each rate the largest legal offset is run with centring on, and offset 0 is run with centring on. These hit the wrap at the end of the frame. Out-of-range offsets, reserved bits and the bypass bit are each applied to a special instance and to a plain instance side by side, which separates the error flag from the way the pulse is formed. A control change made in mid-frame shows that capture happens only at the strobe. Every output cycle of every frame is compared.

// File: rtl/ofp_pkg.sv
package ofp_pkg;

    localparam int CHAN_BITS      = 8;
    localparam int BASE_PULSE_CYC = 4;

    typedef enum logic [1:0] {
        RATE_2M  = 2'd0,
        RATE_4M  = 2'd1,
        RATE_8M  = 2'd2,
        RATE_16M = 2'd3
    } rate_e;

    // raw control word; field positions are fixed by the register layout
    typedef struct packed {
        logic [4:0] rsvd;
        logic       bypass;
        logic [7:0] offset;
        rate_e      rate;
    } ctrl_t;

    // decoded settings for the frame in progress
    typedef struct packed {
        rate_e      rate;
        logic [7:0] offset;
        logic       special;
        logic       act_high;
        logic       centred;
    } cfg_t;

    function automatic int chan_count(rate_e r, int base_chans);
        return base_chans << int'(r);
    endfunction

    function automatic int chan_cycles(rate_e r, int base_cyc);
        return base_cyc >> int'(r);
    endfunction

    function automatic int pulse_cycles(rate_e r);
        int w;
        w = BASE_PULSE_CYC >> int'(r);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/ofp_frame_timer.sv
module ofp_frame_timer #(
    parameter  int FRAME_CYC = 2048,
    localparam int CNT_W     = $clog2(FRAME_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frm_start,
    output logic [CNT_W-1:0] cur_pos,
    output logic             frame_live
);

    logic [CNT_W-1:0] cnt_q;
    logic             synced_q;

    assign cur_pos    = frm_start ? '0 : cnt_q;
    assign frame_live = frm_start | synced_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            synced_q <= 1'b0;
        end else begin
            cnt_q    <= (cur_pos == CNT_W'(FRAME_CYC - 1)) ? '0 : cur_pos + 1'b1;
            synced_q <= synced_q | frm_start;
        end
    end

    // R1: position 0 lies on the strobe cycle, so the next cycle is position 1
    a_r1_cnt_restart: assert property (@(posedge clk) disable iff (rst)
        frm_start |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/ofp_cfg_latch.sv
module ofp_cfg_latch
    import ofp_pkg::*;
#(
    parameter int INST_IDX     = 0,
    parameter int SPECIAL_INST = 2,
    parameter int BASE_CHANS   = 32
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  frm_start,
    input  ctrl_t ctrl_word,
    input  logic  pol_in,
    input  logic  pos_in,
    output cfg_t  cfg,
    output logic  err_q
);

    ctrl_t raw_q;
    logic  pol_q, pos_q;
    ctrl_t cur_raw;
    logic  spec_on, spec_misuse, range_err;
    logic  [31:0] max_off;

    // bypass path lets the strobe cycle itself use the new word
    assign cur_raw = frm_start ? ctrl_word : raw_q;

    generate
        if (INST_IDX == SPECIAL_INST) begin : g_special
            assign spec_on     = cur_raw.bypass;
            assign spec_misuse = 1'b0;
        end else begin : g_plain
            assign spec_on     = 1'b0;
            assign spec_misuse = cur_raw.bypass;
        end
    endgenerate

    assign max_off   = 32'(chan_count(cur_raw.rate, BASE_CHANS) - 1);
    assign range_err = 32'(cur_raw.offset) > max_off;

    always_comb begin
        cfg.rate     = cur_raw.rate;
        cfg.offset   = cur_raw.offset & max_off[7:0];
        cfg.special  = spec_on;
        cfg.act_high = frm_start ? pol_in : pol_q;
        cfg.centred  = frm_start ? pos_in : pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            pol_q <= 1'b0;
            pos_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (frm_start) begin
                raw_q <= ctrl_word;
                pol_q <= pol_in;
                pos_q <= pos_in;
            end
            err_q <= (|cur_raw.rsvd) | range_err | spec_misuse;
        end
    end

    // R8: settings hold for the whole frame
    a_r8_hold_mid_frame: assert property (@(posedge clk) disable iff (rst)
        !frm_start |=> ($stable(raw_q) && $stable(pol_q) && $stable(pos_q)));

    // R4: reserved bits flag an error for the frame
    a_r4_rsvd_err: assert property (@(posedge clk) disable iff (rst)
        (frm_start && (|ctrl_word.rsvd)) |=> err_q);

    // R3: offset beyond the channel count flags an error
    a_r3_range_err: assert property (@(posedge clk) disable iff (rst)
        (frm_start && (32'(ctrl_word.offset) >=
                       32'(chan_count(ctrl_word.rate, BASE_CHANS)))) |=> err_q);

endmodule

// File: rtl/ofp_pulse_shape.sv
module ofp_pulse_shape
    import ofp_pkg::*;
#(
    parameter  int FRAME_CYC     = 2048,
    parameter  int BASE_CHAN_CYC = 64,
    localparam int CNT_W         = $clog2(FRAME_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cur_pos,
    input  logic             frame_live,
    input  cfg_t             cfg,
    output logic             fp_level
);

    logic [31:0]      prod;
    logic [CNT_W-1:0] start_pos, win_start, diff, width, lead;
    logic             hit;
    logic             pulse_q, high_q;
    logic [3:0]       run_q;

    always_comb begin
        prod = 32'(cfg.offset) * 32'(chan_cycles(cfg.rate, BASE_CHAN_CYC));
        if (cfg.special) begin
            start_pos = '0;
            width     = CNT_W'(1);
            lead      = '0;
        end else begin
            start_pos = prod[CNT_W-1:0];
            width     = CNT_W'(pulse_cycles(cfg.rate));
            lead      = cfg.centred ? (width >> 1) : '0;
        end
        win_start = start_pos - lead;
        diff      = cur_pos - win_start;
        hit       = frame_live && (diff < width);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            high_q  <= 1'b0;
        end else begin
            pulse_q <= hit;
            high_q  <= cfg.special ? 1'b0 : cfg.act_high;
        end
    end

    assign fp_level = ~(pulse_q ^ high_q);

    // run-length counter for the width check
    always_ff @(posedge clk) begin
        if (rst)               run_q <= '0;
        else if (!hit)         run_q <= '0;
        else if (run_q != 4'hF) run_q <= run_q + 1'b1;
    end

    // R2: no pulse is ever wider than the widest rate allows
    a_r2_width_cap: assert property (@(posedge clk) disable iff (rst)
        run_q <= 4'(BASE_PULSE_CYC));

    // R9: no pulse before the first reference strobe
    a_r9_idle_unsynced: assert property (@(posedge clk) disable iff (rst)
        !frame_live |=> !pulse_q);

    // R7: the bypass pulse is always active-low
    a_r7_special_low: assert property (@(posedge clk) disable iff (rst)
        cfg.special |=> !high_q);

endmodule

// File: rtl/ofp_gen.sv
module ofp_gen
    import ofp_pkg::*;
#(
    parameter int FRAME_CYC    = 2048,
    parameter int BASE_CHANS   = 32,
    parameter int INST_IDX     = 0,
    parameter int SPECIAL_INST = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frm_start,
    input  logic [15:0] ctrl_word,
    input  logic        pol_sel,
    input  logic        pos_sel,
    output logic        fp_out,
    output logic        cfg_err
);

    localparam int CNT_W         = $clog2(FRAME_CYC);
    localparam int BASE_CHAN_CYC = FRAME_CYC / BASE_CHANS;

    logic [CNT_W-1:0] cur_pos;
    logic             frame_live;
    cfg_t             cfg;

    ofp_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .frm_start  (frm_start),
        .cur_pos    (cur_pos),
        .frame_live (frame_live)
    );

    ofp_cfg_latch #(
        .INST_IDX     (INST_IDX),
        .SPECIAL_INST (SPECIAL_INST),
        .BASE_CHANS   (BASE_CHANS)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .frm_start (frm_start),
        .ctrl_word (ctrl_t'(ctrl_word)),
        .pol_in    (pol_sel),
        .pos_in    (pos_sel),
        .cfg       (cfg),
        .err_q     (cfg_err)
    );

    ofp_pulse_shape #(
        .FRAME_CYC     (FRAME_CYC),
        .BASE_CHAN_CYC (BASE_CHAN_CYC)
    ) u_shape (
        .clk        (clk),
        .rst        (rst),
        .cur_pos    (cur_pos),
        .frame_live (frame_live),
        .cfg        (cfg),
        .fp_level   (fp_out)
    );

    // R9: idle level and clear error straight after reset
    a_r9_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (fp_out && !cfg_err));

endmodule

// File: tb/ofp_gen_test.sv
module ofp_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME      = 2048;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic [15:0] ctrl = '0;
    logic        pol = 1'b0;
    logic        pos = 1'b0;
    logic        fp2, err2, fp0, err0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofp_gen #(.INST_IDX(2)) uut (
        .clk(clk), .rst(rst), .frm_start(strobe), .ctrl_word(ctrl),
        .pol_sel(pol), .pos_sel(pos), .fp_out(fp2), .cfg_err(err2)
    );

    ofp_gen #(.INST_IDX(0)) uut_i0 (
        .clk(clk), .rst(rst), .frm_start(strobe), .ctrl_word(ctrl),
        .pol_sel(pol), .pos_sel(pos), .fp_out(fp0), .cfg_err(err0)
    );

    function automatic logic exp_fp(int inst, logic [15:0] c, logic p, logic q, int k);
        int rate, chan, nch, w, off, s, d;
        bit act;
        rate = int'(c[1:0]);
        if (inst == 2 && c[10]) return !(k == 0);
        chan = 64 >> rate;
        nch  = 32 << rate;
        w    = (rate == 0) ? 4 : (rate == 1) ? 2 : 1;
        off  = int'(c[9:2]) % nch;
        s    = off * chan;
        if (q) s = s - w / 2;
        d    = ((k - s) % FRAME + FRAME) % FRAME;
        act  = d < w;
        return p ? act : !act;
    endfunction

    function automatic logic exp_err(int inst, logic [15:0] c);
        int rate;
        rate = int'(c[1:0]);
        return (c[15:11] != 0) || (int'(c[9:2]) > (32 << rate) - 1) ||
               (inst != 2 && c[10]);
    endfunction

    task automatic cmp(string tag, string what, logic act, logic exp, int k);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s pos=%0d actual=%b expected=%b", tag, what, k, act, exp);
        end
    endtask

    // one full frame under settings c/p/q; at sample chg the inputs switch to c2/p2/q2
    task automatic run_frame(string tag, logic [15:0] c, logic p, logic q,
                             int chg, logic [15:0] c2, logic p2, logic q2);
        @(negedge clk);
        ctrl = c; pol = p; pos = q; strobe = 1'b1;
        for (int k = 0; k < FRAME; k++) begin
            @(negedge clk);
            strobe = 1'b0;
            cmp(tag, "fp inst2",  fp2,  exp_fp(2, c, p, q, k), k);
            cmp(tag, "err inst2", err2, exp_err(2, c), k);
            cmp(tag, "fp inst0",  fp0,  exp_fp(0, c, p, q, k), k);
            cmp(tag, "err inst0", err0, exp_err(0, c), k);
            if (k == chg) begin
                ctrl = c2; pol = p2; pos = q2;
            end
        end
    endtask

    function automatic logic [15:0] mk(int rsvd, bit byp, int off, int rate);
        return {5'(rsvd), byp, 8'(off), 2'(rate)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: idle before first strobe, even with active-high polarity requested
        pol = 1'b1;
        ctrl = mk(0, 0, 5, 0);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cmp("R9", "fp inst2 unsynced",  fp2,  1'b1, k);
            cmp("R9", "err inst2 unsynced", err2, 1'b0, k);
            cmp("R9", "fp inst0 unsynced",  fp0,  1'b1, k);
            cmp("R9", "err inst0 unsynced", err0, 1'b0, k);
        end
        // R1 R2 R5 R6: every rate x polarity x position
        for (int r = 0; r < 4; r++)
            for (int p = 0; p < 2; p++)
                for (int q = 0; q < 2; q++) begin
                    int off;
                    off = (r * 37 + p * 11 + q * 5 + 3) % (32 << r);
                    run_frame("R1/R2/R5/R6", mk(0, 0, off, r), p[0], q[0], -1, '0, 0, 0);
                end
        // R6: wrap of the centred pulse at both frame ends
        for (int r = 0; r < 4; r++) begin
            run_frame("R6 max", mk(0, 0, (32 << r) - 1, r), 1'b1, 1'b1, -1, '0, 0, 0);
            run_frame("R6 zero", mk(0, 0, 0, r), 1'b0, 1'b1, -1, '0, 0, 0);
        end
        // R3: out-of-range offsets wrap and flag
        run_frame("R3", mk(0, 0, 200, 0), 1'b1, 1'b0, -1, '0, 0, 0);
        run_frame("R3", mk(0, 0, 130, 2), 1'b0, 1'b0, -1, '0, 0, 0);
        // R4: reserved bits
        run_frame("R4", mk(5'b00100, 0, 17, 1), 1'b1, 1'b0, -1, '0, 0, 0);
        // R7: bypass bit on special and plain instance
        run_frame("R7", mk(0, 1, 9, 0), 1'b1, 1'b1, -1, '0, 0, 0);
        run_frame("R7", mk(0, 1, 100, 3), 1'b0, 1'b0, -1, '0, 0, 0);
        // R8: mid-frame change, then the new word in the following frame
        run_frame("R8", mk(0, 0, 12, 1), 1'b1, 1'b0, 500, mk(1, 0, 250, 0), 1'b0, 1'b1);
        run_frame("R8 next", mk(1, 0, 250, 0), 1'b0, 1'b1, -1, '0, 0, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule